// File: doc/BRIEF.md
# CAN Bit-Timing Configuration and Quantum Sequencer

This block holds the timing set-up of a CAN controller. Software writes two staging registers and a control register through a simple write port. The staging registers hold the quantum prescaler, the lengths of the two phase segments and the sample mode. The block keeps a separate working copy of these values, and that copy is what the bit-timing logic actually runs on.

Software changes the staging registers only while the controller is held in initialization and is not in bus-off. The working copy is refreshed at one moment only: the cycle in which software takes the controller out of initialization. If both segment lengths are zero, the block refuses that exit and the controller stays in initialization.

Once running, a prescaler counter produces one time-quantum tick every prescaler+1 clocks. A quantum counter then walks through the nominal bit. The bit is one synchronization quantum, then seg1+1 quanta, then seg2+1 quanta. The block gives a one-cycle sample-point pulse on the last quantum of segment 1 and a one-cycle end-of-bit pulse on the last quantum of the bit.

Top module: `can_btcfg`

## Requirements
- R1: After reset is released, init_q is 1, the working outputs brp_q, tseg1_q, tseg2_q and smp_q are all 0, and tq_tick, sample_pt and bit_end are 0.
- R2: Two write addresses hold the timing values. Address 0 carries the prescaler in bits [5:0]. Address 1 carries seg1 in bits [3:0], seg2 in bits [6:4] and the sample mode in bit 7. A write to either address, made while init_q=1 and bus_off=0, is stored in staging but leaves the working outputs unchanged while init_q stays 1.
- R3: A timing write made while bus_off=1 leaves the staging registers unchanged.
- R4: A timing write made while init_q=0 leaves the staging registers unchanged.
- R5: A write of 0 to bit 0 of address 2, made while init_q=1, clears init_q on that edge and copies all staged values to the working outputs. A write of 1 to that bit sets init_q and keeps the working values.
- R6: A write of 0 to bit 0 of address 2 is ignored, and init_q stays 1, when the staged seg1 and seg2 are both zero.
- R7: While init_q=0, tq_tick pulses for one cycle every brp_q+1 clocks. The first pulse comes brp_q cycles after the edge that cleared init_q.
- R8: While init_q=0, bit_end pulses once every (brp_q+1)*(tseg1_q+tseg2_q+3) clocks. sample_pt pulses (brp_q+1)*(tseg1_q+2) clocks after each bit_end, and never in the same cycle as bit_end.
- R9: While init_q=1, tq_tick, sample_pt and bit_end stay 0.
- R10: A one-cycle pulse on can_rst returns the block to the state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| can_rst | input | 1 | Synchronous controller reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 prescaler, 1 segments/sample mode, 2 control |
| wr_data | input | 8 | Write data |
| bus_off | input | 1 | Controller is in bus-off |
| init_q | output | 1 | Initialization bit |
| brp_q | output | 6 | Working prescaler |
| tseg1_q | output | 4 | Working segment 1 length minus one |
| tseg2_q | output | 3 | Working segment 2 length minus one |
| smp_q | output | 1 | Working sample mode |
| tq_tick | output | 1 | Time-quantum tick |
| sample_pt | output | 1 | Sample-point pulse |
| bit_end | output | 1 | Last-quantum-of-bit pulse |

## Verification
The properties assume that wr_en, wr_addr, wr_data, bus_off and can_rst are synchronous to clk and never unknown after reset. They also assume that the working values change only on an init exit or on a reset, so a working-copy stability check is suspended in the cycle after can_rst. The stimulus changes every input on the falling edge and keeps bus_off steady across each write. It pulses can_rst only between scenarios, while no measurement is running.

// File: rtl/can_btcfg.sv
module can_btcfg #(
  parameter int BRP_W  = 6,
  parameter int TS1_W  = 4,
  parameter int TS2_W  = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              can_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bus_off,
  output logic              init_q,
  output logic [BRP_W-1:0]  brp_q,
  output logic [TS1_W-1:0]  tseg1_q,
  output logic [TS2_W-1:0]  tseg2_q,
  output logic              smp_q,
  output logic              tq_tick,
  output logic              sample_pt,
  output logic              bit_end
);
  localparam int NBT_MAX = 3 + (2**TS1_W - 1) + (2**TS2_W - 1);
  localparam int QC_W    = $clog2(NBT_MAX);
  localparam logic [ADDR_W-1:0] A_PRE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SEG = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(2);

  logic [BRP_W-1:0] stg_brp;
  logic [TS1_W-1:0] stg_tseg1;
  logic [TS2_W-1:0] stg_tseg2;
  logic             stg_smp;
  logic [BRP_W-1:0] pc;
  logic [QC_W-1:0]  qc;

  wire tim_ok   = wr_en && init_q && !bus_off;
  wire ctl_wr   = wr_en && (wr_addr == A_CTL);
  wire seg_ok   = (stg_tseg1 != '0) || (stg_tseg2 != '0);
  wire leave    = ctl_wr && init_q && !wr_data[0] && seg_ok;
  wire [QC_W-1:0] sp_idx = QC_W'(tseg1_q) + QC_W'(1);
  wire [QC_W-1:0] last   = QC_W'(tseg1_q) + QC_W'(tseg2_q) + QC_W'(2);

  assign tq_tick   = !init_q && (pc == brp_q);
  assign sample_pt = tq_tick && (qc == sp_idx);
  assign bit_end   = tq_tick && (qc == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_brp <= '0; stg_tseg1 <= '0; stg_tseg2 <= '0; stg_smp <= 1'b0;
    end else if (can_rst) begin
      stg_brp <= '0; stg_tseg1 <= '0; stg_tseg2 <= '0; stg_smp <= 1'b0;
    end else if (tim_ok) begin
      if (wr_addr == A_PRE) stg_brp <= wr_data[BRP_W-1:0];
      if (wr_addr == A_SEG) begin
        stg_tseg1 <= wr_data[TS1_W-1:0];
        stg_tseg2 <= wr_data[TS1_W+TS2_W-1:TS1_W];
        stg_smp   <= wr_data[DATA_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1; brp_q <= '0; tseg1_q <= '0; tseg2_q <= '0; smp_q <= 1'b0;
    end else if (can_rst) begin
      init_q <= 1'b1; brp_q <= '0; tseg1_q <= '0; tseg2_q <= '0; smp_q <= 1'b0;
    end else if (ctl_wr) begin
      if (wr_data[0]) begin
        init_q <= 1'b1;
      end else if (leave) begin
        init_q  <= 1'b0;
        brp_q   <= stg_brp;
        tseg1_q <= stg_tseg1;
        tseg2_q <= stg_tseg2;
        smp_q   <= stg_smp;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; qc <= '0;
    end else if (can_rst || init_q) begin
      pc <= '0; qc <= '0;
    end else begin
      pc <= tq_tick ? '0 : pc + BRP_W'(1);
      if (tq_tick) qc <= (qc == last) ? '0 : qc + QC_W'(1);
    end
  end
endmodule

// File: rtl/can_btcfg_chk.sv
module can_btcfg_chk #(
  parameter int BRP_W = 6,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             can_rst,
  input logic             bus_off,
  input logic             init_q,
  input logic [BRP_W-1:0] brp_q,
  input logic [TS1_W-1:0] tseg1_q,
  input logic [TS2_W-1:0] tseg2_q,
  input logic             smp_q,
  input logic [BRP_W-1:0] stg_brp,
  input logic [TS1_W-1:0] stg_tseg1,
  input logic [TS2_W-1:0] stg_tseg2,
  input logic             stg_smp,
  input logic             tq_tick,
  input logic             sample_pt,
  input logic             bit_end
);
  assert_idle_in_init_R9: assert property (@(posedge clk) disable iff (!rst_n || can_rst)
    init_q |-> (!tq_tick && !sample_pt && !bit_end));

  assert_work_stable_R2: assert property (@(posedge clk) disable iff (!rst_n || can_rst)
    (!$fell(init_q) && !$past(can_rst)) |-> $stable({brp_q, tseg1_q, tseg2_q, smp_q}));

  assert_busoff_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || can_rst)
    bus_off |=> $stable({stg_brp, stg_tseg1, stg_tseg2, stg_smp}));

  assert_run_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || can_rst)
    !init_q |=> $stable({stg_brp, stg_tseg1, stg_tseg2, stg_smp}));

  assert_exit_needs_seg_R6: assert property (@(posedge clk) disable iff (!rst_n || can_rst)
    ($fell(init_q) && !$past(can_rst)) |-> ($past(stg_tseg1) != '0 || $past(stg_tseg2) != '0));

  assert_sample_apart_R8: assert property (@(posedge clk) disable iff (!rst_n || can_rst)
    sample_pt |-> (tq_tick && !bit_end));
endmodule

bind can_btcfg can_btcfg_chk #(.BRP_W(BRP_W), .TS1_W(TS1_W), .TS2_W(TS2_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .can_rst(can_rst), .bus_off(bus_off), .init_q(init_q),
  .brp_q(brp_q), .tseg1_q(tseg1_q), .tseg2_q(tseg2_q), .smp_q(smp_q),
  .stg_brp(stg_brp), .stg_tseg1(stg_tseg1), .stg_tseg2(stg_tseg2), .stg_smp(stg_smp),
  .tq_tick(tq_tick), .sample_pt(sample_pt), .bit_end(bit_end));

// File: tb/can_btcfg_tb_top.sv
module can_btcfg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {brp[5:0], seg1[3:0], seg2[2:0], smp}
  localparam logic [13:0] VEC [NV] = '{
    {6'd0, 4'd1,  3'd0, 1'b0},
    {6'd1, 4'd2,  3'd1, 1'b1},
    {6'd2, 4'd0,  3'd1, 1'b0},
    {6'd3, 4'd4,  3'd2, 1'b1},
    {6'd0, 4'd15, 3'd7, 1'b0},
    {6'd5, 4'd1,  3'd0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, can_rst = 1'b0, wr_en = 1'b0, bus_off = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic init_q, smp_q, tq_tick, sample_pt, bit_end;
  logic [5:0] brp_q;
  logic [3:0] tseg1_q;
  logic [2:0] tseg2_q;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_btcfg dut_i (.clk(clk), .rst_n(rst_n), .can_rst(can_rst), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .bus_off(bus_off), .init_q(init_q),
    .brp_q(brp_q), .tseg1_q(tseg1_q), .tseg2_q(tseg2_q), .smp_q(smp_q),
    .tq_tick(tq_tick), .sample_pt(sample_pt), .bit_end(bit_end));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic sig(input int s);
    return (s == 0) ? tq_tick : (s == 1) ? sample_pt : bit_end;
  endfunction

  task automatic gap(input int from_s, input int to_s, output int cyc);
    int n = 0;
    while (!sig(from_s) && n < 2000) begin @(negedge clk); n++; end
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!sig(to_s) && cyc < 2000);
  endtask

  task automatic idle_check(input string req, input int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      seen += int'(tq_tick) + int'(sample_pt) + int'(bit_end);
    end
    chk(req, seen, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int c, b, t1, t2, sm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 init", init_q, 1);
    chk("R1 work", {brp_q, tseg1_q, tseg2_q, smp_q}, 0);
    idle_check("R1 R9 idle", 10);

    // R6 refused exit with both segments zero
    wr(2'd0, 8'd3);
    wr(2'd2, 8'd0);
    chk("R6 init stays", init_q, 1);
    chk("R6 work unchanged", brp_q, 0);

    // Vector table: R2 R5 R7 R8
    for (int v = 0; v < NV; v++) begin
      {b, t1, t2, sm} = {26'd0, VEC[v][13:8], 28'd0, VEC[v][7:4], 29'd0, VEC[v][3:1], 31'd0, VEC[v][0]};
      b = VEC[v][13:8]; t1 = VEC[v][7:4]; t2 = VEC[v][3:1]; sm = VEC[v][0];
      wr(2'd2, 8'd1);
      wr(2'd0, 8'(b));
      wr(2'd1, {1'(sm), 3'(t2), 4'(t1)});
      if (v > 0) chk("R2 work held in init", brp_q, VEC[v-1][13:8]);
      idle_check("R9 idle in init", 4);
      wr(2'd2, 8'd0);
      chk("R5 init cleared", init_q, 0);
      chk("R5 loaded", {brp_q, tseg1_q, tseg2_q, smp_q}, {b[5:0], t1[3:0], t2[2:0], sm[0]});
      gap(0, 0, c); chk("R7 quantum period", c, b + 1);
      gap(2, 1, c); chk("R8 sample offset", c, (b + 1) * (t1 + 2));
      gap(2, 2, c); chk("R8 bit period", c, (b + 1) * (t1 + t2 + 3));
    end

    // R7 first tick after exit: last vector brp=5
    wr(2'd2, 8'd1);
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd0;
    @(negedge clk); wr_en = 1'b0;
    c = 0;
    while (!tq_tick && c < 100) begin @(negedge clk); c++; end
    chk("R7 first tick", c, 5);

    // R4 writes while running are ignored
    wr(2'd0, 8'd9);
    wr(2'd1, 8'h23);
    wr(2'd2, 8'd1);
    chk("R5 reenter init keeps work", brp_q, 5);
    wr(2'd2, 8'd0);
    chk("R4 prescaler ignored", brp_q, 5);
    chk("R4 segments ignored", {tseg1_q, tseg2_q}, {4'd1, 3'd0});

    // R3 writes during bus-off ignored
    wr(2'd2, 8'd1);
    wr(2'd1, 8'h12);
    bus_off = 1'b1;
    wr(2'd1, 8'h35);
    wr(2'd0, 8'd7);
    bus_off = 1'b0;
    wr(2'd2, 8'd0);
    chk("R3 segments ignored", {tseg1_q, tseg2_q}, {4'd2, 3'd1});
    chk("R3 prescaler ignored", brp_q, 5);

    // R10 controller reset
    @(negedge clk); can_rst = 1'b1;
    @(negedge clk); can_rst = 1'b0;
    chk("R10 init", init_q, 1);
    chk("R10 work", {brp_q, tseg1_q, tseg2_q, smp_q}, 0);
    wr(2'd2, 8'd0);
    chk("R10 staging cleared", init_q, 1);
    idle_check("R10 idle", 6);

    finish_run();
  end
endmodule